// File: doc/BRIEF.md
# Dual-Target External Event Controller

This block watches a group of external event lines and turns them into interrupt, wake-up and event signals for two processor targets. There are two kinds of line. A configurable line is sampled through a synchronizer, and it triggers on a rising edge, a falling edge or both, as selected. A configurable line can also be triggered by software. Any trigger latches a per-line pending flag and produces a one-cycle event pulse. A direct line carries a level straight to the targets as an interrupt and wake-up source. A direct line latches nothing and has no event path.

Each target has its own interrupt mask and its own event mask for every line. The hardware does not arbitrate between the two targets, so firmware must give a line to one target by clearing the other target's masks for that line. A simple write/read register port holds the configuration. The register map is listed below, with the word address in brackets. Configurable lines sit at bits `[N_CFG-1:0]` and direct lines sit at bits `[N_CFG+N_DIR-1:N_CFG]`.

- Edge selection: rising enables [0], falling enables [1]. Both are configurable lines only.
- Software trigger [2]: write only, reads as zero.
- Pending flags [3]: a read returns the flags, and writing a 1 clears that flag.
- Target 0: interrupt mask [4] covering all lines, event mask [5] covering configurable lines.
- Target 1: interrupt mask [6] covering all lines, event mask [7] covering configurable lines.

Top module: `dual_event_ctrl`

## Requirements
- R1: On a configurable line whose rising enable bit (address 0) is set, a 0-to-1 change of the input sets that line's pending flag (address 3). The flag becomes visible on the third clock edge after the change.
- R2: On a configurable line whose falling enable bit (address 1) is set, a 1-to-0 change sets its pending flag. When both enable bits are set, both directions trigger.
- R3: An edge in a direction that is not enabled leaves the pending flag unchanged. A flag, once set, stays set while the input holds steady.
- R4: Writing 1s to the software trigger register (address 2) sets the matching pending flags one cycle after the write. This is the same behaviour as an enabled edge. The register always reads back as zero.
- R5: Writing 1s to the pending register clears those flags, and writing 0s leaves them unchanged. When a trigger and a clear hit the same line in the same cycle, the flag stays set.
- R6: `irq_o[t]` is high exactly when some configurable line has its pending flag set and its bit set in the interrupt mask of target t (address 4 for t=0, address 6 for t=1).
- R7: `evt_o[t]` is a single-cycle pulse in the cycle after a trigger on a line whose bit is set in the event mask of target t (address 5 for t=0, address 7 for t=1). Direct lines never produce an event.
- R8: `irq_o[t]` is also high while a synchronized direct line is high and its bit is set in the interrupt mask of target t. It drops when the line drops, because no flag is kept.
- R9: `wake_o[t]` equals `irq_o[t] | evt_o[t]`.
- R10: The two targets are independent. A line unmasked for both targets drives both, and a mask bit for one target never affects the other.
- R11: While reset is asserted, and right after it, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | N_CFG+N_DIR | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | N_CFG+N_DIR | Read data, combinational from `rd_addr_i` |
| cfg_line_i | input | N_CFG | Configurable event lines (asynchronous) |
| dir_line_i | input | N_DIR | Direct event lines (asynchronous) |
| irq_o | output | 2 | Interrupt request per target |
| wake_o | output | 2 | Wake-up request per target |
| evt_o | output | 2 | Event pulse per target |

## Verification
The bench builds the block with three configurable lines and two direct lines. At that size the sweeps can be complete rather than sampled. They cover every line under all four edge-enable settings in both directions, and every pending pattern against every interrupt-mask split between the two targets. They also cover every combination of direct level and mask. The same configuration makes two corner cases easy to reach. One is a clear that lands in the same cycle as a hardware edge. The other is an event-only wake-up with the interrupt fully masked.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int EVC_ADDR_W = 3;
  localparam int EVC_N_TGT  = 2;

  typedef enum logic [EVC_ADDR_W-1:0] {
    REG_RISE    = 3'd0,
    REG_FALL    = 3'd1,
    REG_SWTRIG  = 3'd2,
    REG_PEND    = 3'd3,
    REG_T0_IMSK = 3'd4,
    REG_T0_EMSK = 3'd5,
    REG_T1_IMSK = 3'd6,
    REG_T1_EMSK = 3'd7
  } evc_reg_e;

endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int N_CFG = 4,
  parameter int N_DIR = 2,
  localparam int NL   = N_CFG + N_DIR
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [EVC_ADDR_W-1:0]             wr_addr_i,
  input  logic [NL-1:0]                     wr_data_i,
  input  logic [EVC_ADDR_W-1:0]             rd_addr_i,
  output logic [NL-1:0]                     rd_data_o,
  input  logic [N_CFG-1:0]                  pend_i,
  output logic [N_CFG-1:0]                  rise_o,
  output logic [N_CFG-1:0]                  fall_o,
  output logic [N_CFG-1:0]                  sw_pulse_o,
  output logic [N_CFG-1:0]                  clr_o,
  output logic [EVC_N_TGT-1:0][NL-1:0]      imsk_o,
  output logic [EVC_N_TGT-1:0][N_CFG-1:0]   emsk_o
);
  logic [N_CFG-1:0]                rise_q, rise_d, fall_q, fall_d, sw_q, sw_d;
  logic [EVC_N_TGT-1:0][NL-1:0]    imsk_q, imsk_d;
  logic [EVC_N_TGT-1:0][N_CFG-1:0] emsk_q, emsk_d;
  logic                            cfg_en;

  // next state
  always_comb begin
    rise_d = rise_q;
    fall_d = fall_q;
    imsk_d = imsk_q;
    emsk_d = emsk_q;
    sw_d   = '0;
    clr_o  = '0;
    cfg_en = 1'b0;
    if (wr_en_i) begin
      case (evc_reg_e'(wr_addr_i))
        REG_RISE:    begin rise_d    = wr_data_i[N_CFG-1:0]; cfg_en = 1'b1; end
        REG_FALL:    begin fall_d    = wr_data_i[N_CFG-1:0]; cfg_en = 1'b1; end
        REG_SWTRIG:  sw_d  = wr_data_i[N_CFG-1:0];
        REG_PEND:    clr_o = wr_data_i[N_CFG-1:0];
        REG_T0_IMSK: begin imsk_d[0] = wr_data_i;             cfg_en = 1'b1; end
        REG_T0_EMSK: begin emsk_d[0] = wr_data_i[N_CFG-1:0];  cfg_en = 1'b1; end
        REG_T1_IMSK: begin imsk_d[1] = wr_data_i;             cfg_en = 1'b1; end
        REG_T1_EMSK: begin emsk_d[1] = wr_data_i[N_CFG-1:0];  cfg_en = 1'b1; end
        default: ;
      endcase
    end
  end

  // configuration registers, written only under cfg_en
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      imsk_q <= '0;
      emsk_q <= '0;
    end else if (cfg_en) begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      imsk_q <= imsk_d;
      emsk_q <= emsk_d;
    end
  end

  // software trigger holds for exactly one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '0;
    else         sw_q <= sw_d;
  end

  // read mux
  always_comb begin
    rd_data_o = '0;
    case (evc_reg_e'(rd_addr_i))
      REG_RISE:    rd_data_o[N_CFG-1:0] = rise_q;
      REG_FALL:    rd_data_o[N_CFG-1:0] = fall_q;
      REG_PEND:    rd_data_o[N_CFG-1:0] = pend_i;
      REG_T0_IMSK: rd_data_o            = imsk_q[0];
      REG_T0_EMSK: rd_data_o[N_CFG-1:0] = emsk_q[0];
      REG_T1_IMSK: rd_data_o            = imsk_q[1];
      REG_T1_EMSK: rd_data_o[N_CFG-1:0] = emsk_q[1];
      default:     rd_data_o            = '0;
    endcase
  end

  assign rise_o     = rise_q;
  assign fall_o     = fall_q;
  assign sw_pulse_o = sw_q;
  assign imsk_o     = imsk_q;
  assign emsk_o     = emsk_q;
endmodule

// File: rtl/evc_cfg_bank.sv
module evc_cfg_bank #(
  parameter int N_CFG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CFG-1:0] line_sync_i,
  input  logic [N_CFG-1:0] rise_i,
  input  logic [N_CFG-1:0] fall_i,
  input  logic [N_CFG-1:0] sw_i,
  input  logic [N_CFG-1:0] clr_i,
  output logic [N_CFG-1:0] trig_o,
  output logic [N_CFG-1:0] pend_o
);
  logic [N_CFG-1:0] prev_q, pend_q, pend_d;

  for (genvar i = 0; i < N_CFG; i++) begin : g_line
    logic went_up, went_down;
    assign went_up   =  line_sync_i[i] & ~prev_q[i];
    assign went_down = ~line_sync_i[i] &  prev_q[i];
    assign trig_o[i] = (went_up & rise_i[i]) | (went_down & fall_i[i]) | sw_i[i];
    // a trigger beats a clear in the same cycle
    assign pend_d[i] = (pend_q[i] & ~clr_i[i]) | trig_o[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_sync_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_TRIG_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |=> ((pend_q & $past(trig_o)) == $past(trig_o))); // R1
  AST_PEND_RISE_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(trig_o)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~trig_o) != '0) |=> ((pend_q & $past(clr_i & ~trig_o)) == '0)); // R5
endmodule

// File: rtl/evc_target.sv
module evc_target #(
  parameter int N_CFG = 4,
  parameter int N_DIR = 2,
  localparam int NL   = N_CFG + N_DIR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CFG-1:0] pend_i,
  input  logic [N_DIR-1:0] dir_i,
  input  logic [N_CFG-1:0] trig_i,
  input  logic [NL-1:0]    imsk_i,
  input  logic [N_CFG-1:0] emsk_i,
  output logic             irq_o,
  output logic             evt_o,
  output logic             wake_o
);
  logic evt_q, evt_d;

  assign irq_o = |({dir_i, pend_i} & imsk_i);
  assign evt_d = |(trig_i & emsk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= evt_d;
  end

  assign evt_o  = evt_q;
  assign wake_o = irq_o | evt_q;
endmodule

// File: rtl/dual_event_ctrl.sv
module dual_event_ctrl
  import evc_pkg::*;
#(
  parameter int N_CFG = 4,
  parameter int N_DIR = 2,
  localparam int NL   = N_CFG + N_DIR
) (
  input  logic                  clk_i,
  input  logic                  arst_ni,
  input  logic                  wr_en_i,
  input  logic [EVC_ADDR_W-1:0] wr_addr_i,
  input  logic [NL-1:0]         wr_data_i,
  input  logic [EVC_ADDR_W-1:0] rd_addr_i,
  output logic [NL-1:0]         rd_data_o,
  input  logic [N_CFG-1:0]      cfg_line_i,
  input  logic [N_DIR-1:0]      dir_line_i,
  output logic [EVC_N_TGT-1:0]  irq_o,
  output logic [EVC_N_TGT-1:0]  wake_o,
  output logic [EVC_N_TGT-1:0]  evt_o
);
  logic                            rst_n;
  logic [N_CFG-1:0]                cfg_sync, rise, fall, sw_pulse, clr, trig, pend;
  logic [N_DIR-1:0]                dir_sync;
  logic [EVC_N_TGT-1:0][NL-1:0]    imsk;
  logic [EVC_N_TGT-1:0][N_CFG-1:0] emsk;

  evc_rst_sync u_rst (.clk_i(clk_i), .arst_ni(arst_ni), .rst_no(rst_n));

  evc_sync #(.W(N_CFG)) u_sync_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .async_i(cfg_line_i), .sync_o(cfg_sync));
  evc_sync #(.W(N_DIR)) u_sync_dir (
    .clk_i(clk_i), .rst_ni(rst_n), .async_i(dir_line_i), .sync_o(dir_sync));

  evc_regs #(.N_CFG(N_CFG), .N_DIR(N_DIR)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pend_i(pend), .rise_o(rise), .fall_o(fall),
    .sw_pulse_o(sw_pulse), .clr_o(clr), .imsk_o(imsk), .emsk_o(emsk));

  evc_cfg_bank #(.N_CFG(N_CFG)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_n), .line_sync_i(cfg_sync),
    .rise_i(rise), .fall_i(fall), .sw_i(sw_pulse), .clr_i(clr),
    .trig_o(trig), .pend_o(pend));

  for (genvar t = 0; t < EVC_N_TGT; t++) begin : g_tgt
    evc_target #(.N_CFG(N_CFG), .N_DIR(N_DIR)) u_tgt (
      .clk_i(clk_i), .rst_ni(rst_n),
      .pend_i(pend), .dir_i(dir_sync), .trig_i(trig),
      .imsk_i(imsk[t]), .emsk_i(emsk[t]),
      .irq_o(irq_o[t]), .evt_o(evt_o[t]), .wake_o(wake_o[t]));
  end

  AST_SW_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sw_pulse != '0) |=> ((pend & $past(sw_pulse)) == $past(sw_pulse))); // R4
  AST_SW_RAISES_EVT: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((sw_pulse & emsk[0]) != '0) |=> evt_o[0]); // R7
  AST_DIR_IRQ_T1: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((dir_sync & imsk[1][NL-1:N_CFG]) != '0) |-> irq_o[1]); // R8
  AST_PEND_IRQ_T0: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend & imsk[0][N_CFG-1:0]) != '0) |-> irq_o[0]); // R6
endmodule

// File: tb/dual_event_ctrl_tb_top.sv
module dual_event_ctrl_tb_top;
  localparam int NC = 3;
  localparam int ND = 2;
  localparam int NL = NC + ND;
  localparam int A_RISE = 0, A_FALL = 1, A_SW = 2, A_PEND = 3;
  localparam int A_I0 = 4, A_E0 = 5, A_I1 = 6, A_E1 = 7;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          wr_en;
  logic [2:0]    wr_addr, rd_addr;
  logic [NL-1:0] wr_data, rd_data;
  logic [NC-1:0] cfg_line;
  logic [ND-1:0] dir_line;
  logic [1:0]    irq, wake, evt;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_event_ctrl #(.N_CFG(NC), .N_DIR(ND)) dut_i (
    .clk_i(clk), .arst_ni(arst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cfg_line_i(cfg_line), .dir_line_i(dir_line),
    .irq_o(irq), .wake_o(wake), .evt_o(evt));

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[NL-1:0];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    rd_addr = a[2:0];
    #1;
    d = int'(rd_data);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    arst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cfg_line = '0; dir_line = '0;
    step(3);
    // R11: outputs low during reset
    chk("R11 irq in reset", int'(irq), 0);
    chk("R11 evt/wake in reset", int'({evt, wake}), 0);
    arst_n = 1'b1;
    step(4);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R11 register reset value", v, 0);
    end

    // R1 R2 R3: every line, every edge selection, both directions
    wr(A_E0, 7);
    for (int l = 0; l < NC; l++) begin
      for (int s = 0; s < 4; s++) begin
        wr(A_RISE, (s & 1) << l);
        wr(A_FALL, ((s >> 1) & 1) << l);
        wr(A_PEND, 7);
        cfg_line = NC'(1 << l);
        step(3);
        rd(A_PEND, v);
        chk("R1 R3 rising edge pending", v, (s & 1) << l);
        chk("R7 event on rising trigger", int'(evt[0]), s & 1);
        step(1);
        chk("R7 event is one cycle", int'(evt[0]), 0);
        rd(A_PEND, v);
        chk("R3 pending holds while input steady", v, (s & 1) << l);
        wr(A_PEND, 7);
        cfg_line = '0;
        step(3);
        rd(A_PEND, v);
        chk("R2 R3 falling edge pending", v, ((s >> 1) & 1) << l);
        chk("R7 event on falling trigger", int'(evt[0]), (s >> 1) & 1);
        step(1);
      end
    end
    wr(A_RISE, 0); wr(A_FALL, 0); wr(A_PEND, 7);

    // R4 R7 R10: software trigger, event mask per target
    wr(A_E0, 5); wr(A_E1, 2);
    for (int p = 1; p < 8; p++) begin
      wr(A_SW, p);
      rd(A_SW, v);
      chk("R4 software trigger reads zero", v, 0);
      rd(A_PEND, v);
      chk("R4 pending not yet set", v, 0);
      step(1);
      rd(A_PEND, v);
      chk("R4 software trigger sets pending", v, p);
      chk("R7 R10 target0 event", int'(evt[0]), int'((p & 5) != 0));
      chk("R7 R10 target1 event", int'(evt[1]), int'((p & 2) != 0));
      step(1);
      chk("R4 no repeat trigger", int'(evt), 0);
      wr(A_PEND, 7);
    end
    wr(A_E0, 0); wr(A_E1, 0);

    // R5: write-one clear, write-zero ignored, edge beats clear
    wr(A_SW, 7); step(1);
    wr(A_PEND, 5);
    rd(A_PEND, v); chk("R5 write one clears", v, 2);
    wr(A_PEND, 0);
    rd(A_PEND, v); chk("R5 write zero ignored", v, 2);
    wr(A_PEND, 7);
    wr(A_RISE, 1);
    wr(A_SW, 1); step(1);
    cfg_line = 3'b001;
    step(2);
    wr(A_PEND, 1);
    rd(A_PEND, v); chk("R5 edge wins over clear", v, 1);
    wr(A_PEND, 7);
    rd(A_PEND, v); chk("R5 clear after collision", v, 0);
    cfg_line = '0; wr(A_RISE, 0); step(3);

    // R6 R9 R10: every pending pattern against every mask split
    for (int p = 0; p < 8; p++) begin
      wr(A_I0, 0); wr(A_I1, 0);
      wr(A_PEND, 7);
      if (p != 0) wr(A_SW, p);
      step(2);
      for (int m = 0; m < 8; m++) begin
        wr(A_I0, m); wr(A_I1, (~m) & 7);
        chk("R6 target0 irq", int'(irq[0]), int'((p & m) != 0));
        chk("R6 R10 target1 irq", int'(irq[1]), int'((p & ~m & 7) != 0));
        chk("R9 wake follows irq", int'(wake), int'(irq));
      end
    end
    wr(A_I0, 0); wr(A_I1, 0); wr(A_PEND, 7);

    // R8 R7: direct lines, level gated, no event, no latch
    wr(A_E0, 7); wr(A_E1, 7);
    for (int d = 0; d < 4; d++) begin
      for (int m = 0; m < 4; m++) begin
        wr(A_I0, m << NC); wr(A_I1, 3 << NC);
        dir_line = ND'(d);
        step(2);
        chk("R8 target0 direct irq", int'(irq[0]), int'((d & m) != 0));
        chk("R8 R10 target1 direct irq", int'(irq[1]), int'(d != 0));
        chk("R7 direct line gives no event", int'(evt), 0);
        chk("R9 wake on direct", int'(wake), int'(irq));
        dir_line = '0;
        step(2);
        chk("R8 direct irq drops with line", int'(irq), 0);
        rd(A_PEND, v);
        chk("R8 direct line keeps no pending", v, 0);
      end
    end

    // R9: event-only wake with interrupt fully masked
    wr(A_I0, 0); wr(A_I1, 0); wr(A_E0, 1); wr(A_E1, 0);
    wr(A_SW, 1); step(1);
    chk("R9 event-only wake target0", int'(wake[0]), 1);
    chk("R9 irq stays masked", int'(irq), 0);
    chk("R10 target1 not woken", int'(wake[1]), 0);
    step(1);
    chk("R9 wake pulse ends", int'(wake[0]), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule